// File: doc/BRIEF.md
# Link-Layer Retry and Credit Controller

This block is the link-layer control for one direction of a full-duplex point-to-point link, together with the receive half that watches the opposite direction. On the send side it accepts a 72-bit payload tagged with a message class. It adds an 8-bit CRC to form an 80-bit flit and gives the flit an 8-bit sequence number. A copy stays in a 16-entry replay store until the far end acknowledges it. A flit is accepted only when three conditions hold: the class still has a credit for receiver buffer space, the replay store has room, and no replay is in progress.

On the receive side every incoming flit is checked against its CRC. A good flit that carries the expected sequence number is passed upward and acknowledged with a control flit on the return path. A flit with a bad CRC is discarded, and the block returns a retry request that names the sequence number it still expects. When the send side gets such a request, it resends from the named flit onward. Buffer slots that the upper layer releases go back to the far sender as per-class credit returns.

Top module: `link_retry_ctl`

## Requirements
- R1: An accepted payload appears one cycle later on `lo_flit` as {payload[71:0], crc[7:0]}. The CRC uses the polynomial x^8+x^2+x+1 (0x07), starts from zero and is computed over payload bit 71 down to bit 0. `lo_seq` starts at 0 after reset and increases by one, modulo 256, for each new flit.
- R2: An incoming flit with a correct CRC and `li_seq` equal to the expected number is delivered on `rx_payload`/`rx_class` with `rx_valid` one cycle later. In that same cycle an acknowledge goes out on `co_valid`=1, `co_nak`=0, `co_seq`=that sequence number, and the expected number then advances.
- R3: An incoming flit with a CRC mismatch is never delivered and does not advance the expected number. One cycle later it produces `co_valid`=1, `co_nak`=1, `co_seq`=the expected number.
- R4: A flit with a correct CRC whose sequence number differs from the expected one is dropped silently: nothing is delivered and no control flit is sent.
- R5: A retry request (`ci_valid`=1, `ci_nak`=1, `ci_seq`=s) makes the sender resend flits s, s+1, … up to the last one sent, one per cycle and in order. The resend starts on the second clock edge after the request. `tx_ready` stays low during the resend, and resends take no credit.
- R6: Each of the six classes 0..5 starts with CREDITS (default 4) credits, and each new flit uses one credit of its class. `tx_ready` is low for a class that has none left. Class codes 6 and 7 are never accepted.
- R7: A credit return (`cr_in_valid` with `cr_in_class`) adds one credit to that class. The count never rises above CREDITS, so extra returns are ignored.
- R8: At most 16 flits are unacknowledged at once, and `tx_ready` is low while 16 are outstanding. An acknowledge (`ci_nak`=0, `ci_seq`=s) releases every flit up to and including s.
- R9: `rx_free` with `rx_free_class` gives `cr_out_valid`=1 and `cr_out_class` equal to that class one cycle later.
- R10: After reset, `lo_valid`, `rx_valid`, `co_valid` and `cr_out_valid` are 0, and `tx_ready` is 1 for classes 0..5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Upper layer offers a payload |
| tx_class | input | 3 | Message class of the offered payload |
| tx_payload | input | 72 | Offered payload |
| tx_ready | output | 1 | Payload accepted this cycle when tx_valid is high |
| lo_valid | output | 1 | Outgoing flit valid |
| lo_flit | output | 80 | Outgoing flit {payload, crc} |
| lo_seq | output | 8 | Sequence number of the outgoing flit |
| lo_class | output | 3 | Class of the outgoing flit |
| ci_valid | input | 1 | Control flit from the far receiver |
| ci_nak | input | 1 | 1 = retry request, 0 = acknowledge |
| ci_seq | input | 8 | Sequence number carried by the control flit |
| cr_in_valid | input | 1 | Credit return from the far receiver |
| cr_in_class | input | 3 | Class of the returned credit |
| li_valid | input | 1 | Incoming flit valid |
| li_flit | input | 80 | Incoming flit {payload, crc} |
| li_seq | input | 8 | Sequence number of the incoming flit |
| li_class | input | 3 | Class of the incoming flit |
| rx_valid | output | 1 | Delivered payload valid |
| rx_payload | output | 72 | Delivered payload |
| rx_class | output | 3 | Class of the delivered payload |
| co_valid | output | 1 | Control flit to the far sender |
| co_nak | output | 1 | 1 = retry request, 0 = acknowledge |
| co_seq | output | 8 | Sequence number in the control flit |
| rx_free | input | 1 | Upper layer released one receive slot |
| rx_free_class | input | 3 | Class of the released slot |
| cr_out_valid | output | 1 | Credit return to the far sender |
| cr_out_class | output | 3 | Class of the returned credit |

## Verification
A wrong replay pointer or acknowledge pointer shows up within two cycles of a retry request. `lo_seq` or `lo_flit` then carries the wrong flit, and in the looped-back run the delivered stream gains a gap or a duplicate. A credit counter that drifts appears at `tx_ready` as soon as a class is driven to its limit or past it. A fault in the receive sequence tracker makes the first flit after a corrupted one go missing, or get acknowledged twice, on the cycle after it arrives. The bench also loops the link back on itself with two corrupted flits and compares the delivered payloads, in order, against what was offered.

// File: rtl/link_retry_ctl.sv
module link_retry_ctl #(
  parameter int PW      = 72,
  parameter int SEQW    = 8,
  parameter int DEPTH   = 16,
  parameter int NCLS    = 6,
  parameter int CLSW    = 3,
  parameter int CREDITS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_valid,
  input  logic [CLSW-1:0] tx_class,
  input  logic [PW-1:0]   tx_payload,
  output logic            tx_ready,
  output logic            lo_valid,
  output logic [PW+7:0]   lo_flit,
  output logic [SEQW-1:0] lo_seq,
  output logic [CLSW-1:0] lo_class,
  input  logic            ci_valid,
  input  logic            ci_nak,
  input  logic [SEQW-1:0] ci_seq,
  input  logic            cr_in_valid,
  input  logic [CLSW-1:0] cr_in_class,
  input  logic            li_valid,
  input  logic [PW+7:0]   li_flit,
  input  logic [SEQW-1:0] li_seq,
  input  logic [CLSW-1:0] li_class,
  output logic            rx_valid,
  output logic [PW-1:0]   rx_payload,
  output logic [CLSW-1:0] rx_class,
  output logic            co_valid,
  output logic            co_nak,
  output logic [SEQW-1:0] co_seq,
  input  logic            rx_free,
  input  logic [CLSW-1:0] rx_free_class,
  output logic            cr_out_valid,
  output logic [CLSW-1:0] cr_out_class
);
  localparam int IW  = $clog2(DEPTH);
  localparam int CRW = $clog2(CREDITS + 1);
  localparam int NCODE = 1 << CLSW;
  localparam logic [SEQW:0]  DEPTH_W = (SEQW+1)'(DEPTH);
  localparam logic [CRW-1:0] CAP     = CRW'(CREDITS);

  function automatic logic [7:0] crc8(input logic [PW-1:0] d);
    logic [7:0] c;
    logic fb;
    c = '0;
    for (int i = PW - 1; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  logic [CLSW+PW-1:0] rbuf [DEPTH];
  logic [SEQW-1:0] nxt_seq, ack_ptr, rp, exp_seq, nxt_d;
  logic            replaying;
  logic [NCODE-1:0] cls_has;
  logic [SEQW-1:0] outstanding;
  logic            take_new, nak_in, ack_in, crc_ok, in_order;
  logic [PW-1:0]   sel_payload;
  logic [CLSW-1:0] sel_class;

  assign outstanding = nxt_seq - ack_ptr;
  assign tx_ready    = !replaying && ({1'b0, outstanding} < DEPTH_W) && cls_has[tx_class];
  assign take_new    = tx_valid && tx_ready;
  assign nak_in      = ci_valid && ci_nak;
  assign ack_in      = ci_valid && !ci_nak;
  assign nxt_d       = nxt_seq + SEQW'(take_new);
  assign {sel_class, sel_payload} = replaying ? rbuf[rp[IW-1:0]] : {tx_class, tx_payload};

  // Per-class credit counters
  for (genvar g = 0; g < NCODE; g++) begin : g_cls
    if (g < NCLS) begin : g_cnt
      logic [CRW-1:0] cnt;
      logic use_c, ret_c;
      assign use_c = take_new && (tx_class == CLSW'(g));
      assign ret_c = cr_in_valid && (cr_in_class == CLSW'(g));
      always_ff @(posedge clk) begin
        if (!rst_n)                               cnt <= CAP;
        else if (use_c && !ret_c)                 cnt <= cnt - 1'b1;
        else if (ret_c && !use_c && cnt != CAP)   cnt <= cnt + 1'b1;
      end
      assign cls_has[g] = (cnt != '0);
      AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CAP); // R7
    end else begin : g_pad
      assign cls_has[g] = 1'b0;
    end
  end

  // Send side control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_seq   <= '0;
      ack_ptr   <= '0;
      rp        <= '0;
      replaying <= 1'b0;
      lo_valid  <= 1'b0;
    end else begin
      lo_valid <= replaying || take_new;
      if (replaying) begin
        rp <= rp + 1'b1;
        if (rp + 1'b1 == nxt_seq) replaying <= 1'b0;
      end else if (take_new) begin
        nxt_seq <= nxt_seq + 1'b1;
      end
      if (nak_in) begin
        ack_ptr   <= ci_seq;
        rp        <= ci_seq;
        replaying <= (ci_seq != nxt_d);
      end else if (ack_in) begin
        ack_ptr <= ci_seq + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take_new && !replaying) rbuf[nxt_seq[IW-1:0]] <= {tx_class, tx_payload};
    if (replaying || take_new) begin
      lo_flit  <= {sel_payload, crc8(sel_payload)};
      lo_seq   <= replaying ? rp : nxt_seq;
      lo_class <= sel_class;
    end
  end

  // Receive side
  assign crc_ok   = (li_flit[7:0] == crc8(li_flit[PW+7:8]));
  assign in_order = (li_seq == exp_seq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid     <= 1'b0;
      rx_payload   <= '0;
      rx_class     <= '0;
      co_valid     <= 1'b0;
      co_nak       <= 1'b0;
      co_seq       <= '0;
      exp_seq      <= '0;
      cr_out_valid <= 1'b0;
      cr_out_class <= '0;
    end else begin
      rx_valid     <= li_valid && crc_ok && in_order;
      rx_payload   <= li_flit[PW+7:8];
      rx_class     <= li_class;
      co_valid     <= li_valid && (!crc_ok || in_order);
      co_nak       <= !crc_ok;
      co_seq       <= exp_seq;
      if (li_valid && crc_ok && in_order) exp_seq <= exp_seq + 1'b1;
      cr_out_valid <= rx_free;
      cr_out_class <= rx_free_class;
    end
  end

  AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) {1'b0, outstanding} <= DEPTH_W); // R8
  AST_REPLAY_EMITS: assert property (@(posedge clk) disable iff (!rst_n) replaying |=> lo_valid); // R5
  AST_NAK_NO_DELIVER: assert property (@(posedge clk) disable iff (!rst_n) (co_valid && co_nak) |-> !rx_valid); // R3
  AST_DELIVER_ACKED: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> (co_valid && !co_nak)); // R2
  AST_BAD_CLASS: assert property (@(posedge clk) disable iff (!rst_n) (tx_class >= CLSW'(NCLS)) |-> !tx_ready); // R6
endmodule

// File: tb/link_retry_ctl_tb.sv
module link_retry_ctl_tb;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n = 0;
  logic tx_valid = 0; logic [2:0] tx_class = 0; logic [71:0] tx_payload = 0;
  logic tx_ready, lo_valid; logic [79:0] lo_flit; logic [7:0] lo_seq; logic [2:0] lo_class;
  logic m_ci_valid = 0, m_ci_nak = 0; logic [7:0] m_ci_seq = 0;
  logic m_cr_valid = 0; logic [2:0] m_cr_class = 0;
  logic m_li_valid = 0; logic [79:0] m_li_flit = 0; logic [7:0] m_li_seq = 0; logic [2:0] m_li_class = 0;
  logic m_free = 0; logic [2:0] m_free_class = 0;
  logic ci_valid, ci_nak, cr_in_valid, li_valid, rx_free;
  logic [7:0] ci_seq, li_seq, co_seq; logic [2:0] cr_in_class, li_class, rx_free_class, rx_class, cr_out_class;
  logic [79:0] li_flit; logic rx_valid, co_valid, co_nak, cr_out_valid; logic [71:0] rx_payload;

  logic lb = 0;
  int cidx = 0; bit clr_next = 0;
  logic [7:0] tgt;
  logic corrupt;
  assign tgt     = (cidx == 0) ? 8'd3 : 8'd10;
  assign corrupt = lb && cidx < 2 && lo_valid && lo_seq == tgt;

  assign ci_valid      = lb ? co_valid : m_ci_valid;
  assign ci_nak        = lb ? co_nak : m_ci_nak;
  assign ci_seq        = lb ? co_seq : m_ci_seq;
  assign cr_in_valid   = lb ? cr_out_valid : m_cr_valid;
  assign cr_in_class   = lb ? cr_out_class : m_cr_class;
  assign li_valid      = lb ? lo_valid : m_li_valid;
  assign li_flit       = lb ? (lo_flit ^ (corrupt ? 80'h100 : 80'h0)) : m_li_flit;
  assign li_seq        = lb ? lo_seq : m_li_seq;
  assign li_class      = lb ? lo_class : m_li_class;
  assign rx_free       = lb ? rx_valid : m_free;
  assign rx_free_class = lb ? rx_class : m_free_class;

  link_retry_ctl u_dut (
    .clk, .rst_n, .tx_valid, .tx_class, .tx_payload, .tx_ready,
    .lo_valid, .lo_flit, .lo_seq, .lo_class,
    .ci_valid, .ci_nak, .ci_seq, .cr_in_valid, .cr_in_class,
    .li_valid, .li_flit, .li_seq, .li_class,
    .rx_valid, .rx_payload, .rx_class, .co_valid, .co_nak, .co_seq,
    .rx_free, .rx_free_class, .cr_out_valid, .cr_out_class);

  int checks = 0, fails = 0;
  int ndel = 0, naks = 0;
  logic [71:0] dlog [64];
  logic got_valid; logic [79:0] got_flit; logic [7:0] got_seq;

  always @(negedge clk) begin
    if (lb) begin
      if (clr_next) begin clr_next = 0; cidx++; end
      else if (corrupt) clr_next = 1;
      if (co_valid && co_nak) naks++;
      if (rx_valid && ndel < 64) begin dlog[ndel] = rx_payload; ndel++; end
    end
  end

  function automatic logic [7:0] ref_crc(input logic [71:0] p);
    logic [7:0] c = 8'h00;
    for (int b = 8; b >= 0; b--) begin
      c ^= p[b*8 +: 8];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; lb = 0; tx_valid = 0; m_ci_valid = 0; m_cr_valid = 0; m_li_valid = 0; m_free = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic send(input logic [2:0] c, input logic [71:0] p);
    bit r = 0;
    while (!r) begin
      @(negedge clk); tx_valid = 1; tx_class = c; tx_payload = p;
      #1 r = tx_ready;
      @(posedge clk);
    end
    #1 got_valid = lo_valid; got_flit = lo_flit; got_seq = lo_seq;
    @(negedge clk); tx_valid = 0;
  endtask

  function automatic bit ready_for(input logic [2:0] c);
    tx_class = c;
    return 1'b0;
  endfunction

  task automatic probe(input logic [2:0] c, output bit r);
    @(negedge clk); tx_class = c; #1 r = tx_ready;
  endtask

  task automatic t_reset();
    bit r;
    do_reset();
    #1;
    chk(!lo_valid && !rx_valid && !co_valid && !cr_out_valid, "R10 outputs idle",
        {lo_valid, rx_valid, co_valid, cr_out_valid}, 0);
    for (int c = 0; c < 6; c++) begin
      probe(3'(c), r);
      chk(r, "R10 ready per class", r, 1);
    end
  endtask

  task automatic t_format();
    logic [71:0] pats [3];
    pats[0] = 72'h0; pats[1] = {72{1'b1}}; pats[2] = 72'hA5_1234_5678_9ABC_DEF0;
    do_reset();
    for (int i = 0; i < 3; i++) begin
      send(3'd1, pats[i]);
      chk(got_valid && got_flit == {pats[i], ref_crc(pats[i])}, "R1 flit image",
          got_flit, {pats[i], ref_crc(pats[i])});
      chk(got_seq == 8'(i), "R1 sequence", got_seq, i);
    end
  endtask

  task automatic t_rx();
    logic [71:0] p0 = 72'h11_2233_4455_6677_8899, p1 = 72'hFE_DCBA_9876_5432_10AA;
    do_reset();
    @(negedge clk); m_li_valid = 1; m_li_flit = {p0, ref_crc(p0)}; m_li_seq = 0; m_li_class = 3'd4;
    @(posedge clk); #1;
    chk(rx_valid && rx_payload == p0 && rx_class == 3'd4, "R2 deliver", rx_payload, p0);
    chk(co_valid && !co_nak && co_seq == 0, "R2 ack", {co_valid, co_nak, co_seq}, {2'b10, 8'd0});
    @(negedge clk); m_li_flit = {p1, ref_crc(p1) ^ 8'h01}; m_li_seq = 1;
    @(posedge clk); #1;
    chk(!rx_valid, "R3 bad crc dropped", rx_valid, 0);
    chk(co_valid && co_nak && co_seq == 1, "R3 nak", {co_valid, co_nak, co_seq}, {2'b11, 8'd1});
    @(negedge clk); m_li_flit = {p1, ref_crc(p1)}; m_li_seq = 5;
    @(posedge clk); #1;
    chk(!rx_valid && !co_valid, "R4 out of order silent", {rx_valid, co_valid}, 0);
    @(negedge clk); m_li_seq = 1;
    @(posedge clk); #1;
    chk(rx_valid && rx_payload == p1 && co_seq == 1 && !co_nak, "R3 expected held", {co_seq, rx_payload}, {8'd1, p1});
    @(negedge clk); m_li_valid = 0; m_free = 1; m_free_class = 3'd4;
    @(posedge clk); #1;
    chk(cr_out_valid && cr_out_class == 3'd4, "R9 credit out", {cr_out_valid, cr_out_class}, {1'b1, 3'd4});
    @(negedge clk); m_free = 0;
    @(posedge clk); #1;
    chk(!cr_out_valid, "R9 single pulse", cr_out_valid, 0);
  endtask

  task automatic t_credits();
    bit r;
    do_reset();
    for (int i = 0; i < 4; i++) send(3'd2, 72'(i));
    probe(3'd2, r); chk(!r, "R6 class out of credit", r, 0);
    probe(3'd3, r); chk(r, "R6 other class ready", r, 1);
    probe(3'd6, r); chk(!r, "R6 class 6 rejected", r, 0);
    probe(3'd7, r); chk(!r, "R6 class 7 rejected", r, 0);
    @(negedge clk); m_cr_valid = 1; m_cr_class = 3'd2;
    @(negedge clk); m_cr_valid = 0;
    probe(3'd2, r); chk(r, "R7 return restores", r, 1);
    @(negedge clk); m_cr_valid = 1; m_cr_class = 3'd3;
    repeat (3) @(negedge clk);
    m_cr_valid = 0;
    for (int i = 0; i < 4; i++) send(3'd3, 72'(i + 100));
    probe(3'd3, r); chk(!r, "R7 count capped", r, 0);
  endtask

  task automatic t_window();
    bit r;
    do_reset();
    for (int i = 0; i < 16; i++) send(3'(i % 6), 72'(i));
    probe(3'd5, r); chk(!r, "R8 window full", r, 0);
    @(negedge clk); m_ci_valid = 1; m_ci_nak = 0; m_ci_seq = 8'd7;
    @(negedge clk); m_ci_valid = 0;
    probe(3'd5, r); chk(r, "R8 ack frees window", r, 1);
  endtask

  task automatic t_replay();
    logic [71:0] p [3];
    bit r;
    p[0] = 72'hAA; p[1] = 72'hBB_CC00_0000_0000_0001; p[2] = 72'h12_3456;
    do_reset();
    for (int i = 0; i < 3; i++) send(3'd0, p[i]);
    @(negedge clk); tx_class = 0; m_ci_valid = 1; m_ci_nak = 1; m_ci_seq = 8'd1;
    @(posedge clk); #1;
    chk(!tx_ready, "R5 ready low in replay", tx_ready, 0);
    @(negedge clk); m_ci_valid = 0;
    for (int i = 1; i < 3; i++) begin
      @(posedge clk); #1;
      chk(lo_valid && lo_seq == 8'(i) && lo_flit == {p[i], ref_crc(p[i])}, "R5 resend order",
          {lo_seq, lo_flit[71:0]}, {8'(i), p[i][63:0], ref_crc(p[i])});
    end
    @(posedge clk); #1;
    chk(!lo_valid, "R5 replay ends", lo_valid, 0);
    probe(3'd0, r); chk(r, "R5 no credit spent on resend", r, 1);
  endtask

  task automatic t_loop();
    do_reset();
    @(negedge clk); lb = 1; cidx = 0; clr_next = 0; ndel = 0; naks = 0;
    for (int i = 0; i < 40; i++) send(3'(i % 6), {8'(i), 64'h0F0F_1234_0000_0000 + 64'(i * 977)});
    repeat (60) @(posedge clk);
    #1;
    chk(naks == 2, "R3 loop naks", naks, 2);
    chk(ndel == 40, "R5 loop delivery count", ndel, 40);
    for (int i = 0; i < 40 && i < ndel; i++)
      chk(dlog[i] == {8'(i), 64'h0F0F_1234_0000_0000 + 64'(i * 977)}, "R5 loop order", dlog[i],
          {8'(i), 64'h0F0F_1234_0000_0000 + 64'(i * 977)});
  endtask

  initial begin
    t_reset();
    t_format();
    t_rx();
    t_credits();
    t_window();
    t_replay();
    t_loop();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule